// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Controller

This block is the tag and state engine of a set-associative cache that uses write-back with write-allocate. The level above hands it one read or write at a time, each with a 32-bit byte address. The controller looks the address up in its tag store and tracks validity, dirtiness and recency for every way. On a miss it frees a way and then fetches the requested block from the level below. Only tags and state are held. No data payload passes through the block.

The level below is reached through a single request port that is held until it is acknowledged. A command on that port is either a whole-block write of an evicted dirty block or a whole-block read of the requested block. Both carry a block-aligned address. Geometry comes from three parameters: total bytes, number of ways and bytes per block. Five running counters report read hits, read misses, write hits, write misses and writebacks.

Top module: `wbCacheCtrl`

## Requirements
- R1: The set count is CACHE_BYTES / (WAYS × BLOCK_BYTES), and both the block size and the set count are powers of two. Address bits [OFF_W-1:0] are the byte offset, the next IDX_W bits are the set index and the remaining upper bits are the tag. Two addresses that differ only in their offset hit the same block.
- R2: A request to a resident block finishes with `rspValid` high and `rspHit`=1, and it issues no next-level command.
- R3: If a miss finds an invalid way in its set, the lowest-numbered invalid way is filled. Exactly one block read is issued (`memReqWrite`=0), and its address is {tag, set, zero offset}. Nothing is evicted.
- R4: A write, whether it hits or misses, leaves its block dirty. A write hit issues no next-level command.
- R5: If a miss finds every way of its set valid, the victim is the least recently used way. When that victim is clean, the only command issued is the block read.
- R6: When the victim is dirty, a block write (`memReqWrite`=1) carrying the victim's address {victim tag, set, zero} is issued and acknowledged before the block read of the requested block.
- R7: Every completed request, hit or miss, makes the accessed way the most recently used way of its set.
- R8: `reqReady` is high only when the controller is idle, and only one request is in flight at a time. `memReqValid`, `memReqWrite` and `memReqAddr` stay steady until `memAck`.
- R9: Each request adds exactly one to exactly one of the four hit/miss counters, chosen by its kind and its outcome. The writeback counter counts dirty evictions. All counters update on the edge that ends the response cycle.
- R10: After reset every way is invalid, all counters are zero, `reqReady`=1 and `memReqValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered while ready |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqAddr | input | 32 | Byte address of the request |
| reqReady | output | 1 | Controller idle and accepting |
| rspValid | output | 1 | One-cycle completion pulse |
| rspHit | output | 1 | Completed request was a hit |
| memReqValid | output | 1 | Next-level command pending |
| memReqWrite | output | 1 | 1 = block write (eviction), 0 = block read |
| memReqAddr | output | 32 | Block-aligned next-level address |
| memAck | input | 1 | Next level accepts the pending command |
| statReadHit | output | 32 | Read hit count |
| statReadMiss | output | 32 | Read miss count |
| statWriteHit | output | 32 | Write hit count |
| statWriteMiss | output | 32 | Write miss count |
| statWriteback | output | 32 | Dirty eviction count |

## Verification
A directed sequence drives a single set through four phases: cold fills into invalid ways, a re-touch of an old block, clean evictions and finally the eviction of a block that was earlier written. This pattern separates a true LRU choice from a fill-order or round-robin choice, and it shows whether a writeback is ordered ahead of the fetch. Repeated hits at different byte offsets and in neighbouring sets confirm that the address split is correct and that sets are isolated from one another. A long pseudo-random mix of reads and writes over a few tags in a few sets then runs against a recency-list model, which checks the hit flag and every next-level command one by one.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WB, ST_FETCH, ST_UPDATE
  } ctrlState_t;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic latchReq;     // capture the incoming request
    logic latchLookup;  // capture the chosen way, hit and victim facts
    logic commit;       // write tag/state, recency and counters
    logic selVictim;    // drive the victim's block address to the next level
  } ctrlStrobe_t;
endpackage

// File: rtl/wbcDatapath.sv
module wbcDatapath #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wbc_pkg::ctrlStrobe_t strobe,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 lookHit,
  output logic                 lookFree,
  output logic                 lookDirty,
  output logic                 rspHit,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic [31:0]          statReadHit,
  output logic [31:0]          statReadMiss,
  output logic [31:0]          statWriteHit,
  output logic [31:0]          statWriteMiss,
  output logic [31:0]          statWriteback
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int RANK_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [RANK_W-1:0] LRU_RANK = RANK_W'(WAYS - 1);

  logic [TAG_W-1:0]  tagMem   [SETS][WAYS];
  logic              validMem [SETS][WAYS];
  logic              dirtyMem [SETS][WAYS];
  logic [RANK_W-1:0] rankMem  [SETS][WAYS];

  logic              writeQ, hitQ, wbQ;
  logic [TAG_W-1:0]  tagQ, victimTagQ;
  logic [IDX_W-1:0]  setQ;
  logic [RANK_W-1:0] wayQ;

  logic              hitAny, freeAny;
  logic [RANK_W-1:0] hitIdx, freeIdx, victimIdx, pickIdx;

  // lookup over the latched set; downward scan favours the lowest index
  always_comb begin
    hitAny = 1'b0; freeAny = 1'b0;
    hitIdx = '0; freeIdx = '0; victimIdx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (validMem[setQ][w] && tagMem[setQ][w] == tagQ) begin
        hitAny = 1'b1; hitIdx = RANK_W'(w);
      end
      if (!validMem[setQ][w]) begin
        freeAny = 1'b1; freeIdx = RANK_W'(w);
      end
      if (rankMem[setQ][w] == LRU_RANK) victimIdx = RANK_W'(w);
    end
    pickIdx = hitAny ? hitIdx : (freeAny ? freeIdx : victimIdx);
  end

  assign lookHit    = hitAny;
  assign lookFree   = freeAny;
  assign lookDirty  = dirtyMem[setQ][victimIdx];
  assign rspHit     = hitQ;
  assign memReqAddr = {strobe.selVictim ? victimTagQ : tagQ, setQ, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeQ <= 1'b0; hitQ <= 1'b0; wbQ <= 1'b0;
      tagQ <= '0; victimTagQ <= '0; setQ <= '0; wayQ <= '0;
    end else begin
      if (strobe.latchReq) begin
        writeQ <= reqWrite;
        tagQ   <= reqAddr[ADDR_W-1 -: TAG_W];
        setQ   <= reqAddr[OFF_W +: IDX_W];
      end
      if (strobe.latchLookup) begin
        wayQ       <= pickIdx;
        hitQ       <= hitAny;
        wbQ        <= !hitAny && !freeAny && dirtyMem[setQ][victimIdx];
        victimTagQ <= tagMem[setQ][victimIdx];
      end
    end
  end

  // tag/state store with recency ranks (0 = most recent)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w]   <= '0;
          validMem[s][w] <= 1'b0;
          dirtyMem[s][w] <= 1'b0;
          rankMem[s][w]  <= RANK_W'(w);
        end
      end
    end else if (strobe.commit) begin
      tagMem[setQ][wayQ]   <= tagQ;
      validMem[setQ][wayQ] <= 1'b1;
      dirtyMem[setQ][wayQ] <= writeQ | (hitQ & dirtyMem[setQ][wayQ]);
      for (int w = 0; w < WAYS; w++) begin
        if (RANK_W'(w) == wayQ)
          rankMem[setQ][w] <= '0;
        else if (rankMem[setQ][w] < rankMem[setQ][wayQ])
          rankMem[setQ][w] <= rankMem[setQ][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReadHit <= '0; statReadMiss <= '0;
      statWriteHit <= '0; statWriteMiss <= '0; statWriteback <= '0;
    end else if (strobe.commit) begin
      if (!writeQ &&  hitQ) statReadHit   <= statReadHit + 32'd1;
      if (!writeQ && !hitQ) statReadMiss  <= statReadMiss + 32'd1;
      if ( writeQ &&  hitQ) statWriteHit  <= statWriteHit + 32'd1;
      if ( writeQ && !hitQ) statWriteMiss <= statWriteMiss + 32'd1;
      if (wbQ)              statWriteback <= statWriteback + 32'd1;
    end
  end
endmodule

// File: rtl/wbcControl.sv
module wbcControl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 lookHit,
  input  logic                 lookFree,
  input  logic                 lookDirty,
  input  logic                 memAck,
  output logic                 reqReady,
  output logic                 rspValid,
  output logic                 memReqValid,
  output logic                 memReqWrite,
  output wbc_pkg::ctrlStrobe_t strobe
);
  import wbc_pkg::*;

  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_LOOKUP;
      ST_LOOKUP: begin
        if (lookHit || lookFree)  stateNext = lookHit ? ST_UPDATE : ST_FETCH;
        else                      stateNext = lookDirty ? ST_WB : ST_FETCH;
      end
      ST_WB:     if (memAck) stateNext = ST_FETCH;
      ST_FETCH:  if (memAck) stateNext = ST_UPDATE;
      ST_UPDATE: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == ST_IDLE);
  assign rspValid    = (state == ST_UPDATE);
  assign memReqValid = (state == ST_WB) || (state == ST_FETCH);
  assign memReqWrite = (state == ST_WB);

  always_comb begin
    strobe.latchReq    = (state == ST_IDLE) && reqValid;
    strobe.latchLookup = (state == ST_LOOKUP);
    strobe.commit      = (state == ST_UPDATE);
    strobe.selVictim   = (state == ST_WB);
  end
endmodule

// File: rtl/wbCacheCtrl.sv
module wbCacheCtrl #(
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int BLOCK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  output logic        reqReady,
  output logic        rspValid,
  output logic        rspHit,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic [31:0] memReqAddr,
  input  logic        memAck,
  output logic [31:0] statReadHit,
  output logic [31:0] statReadMiss,
  output logic [31:0] statWriteHit,
  output logic [31:0] statWriteMiss,
  output logic [31:0] statWriteback
);
  localparam int ADDR_W = 32;
  localparam int SETS   = CACHE_BYTES / (WAYS * BLOCK_BYTES);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(SETS);

  wbc_pkg::ctrlStrobe_t strobe;
  logic lookHit, lookFree, lookDirty;

  wbcControl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .lookHit(lookHit), .lookFree(lookFree), .lookDirty(lookDirty),
    .memAck(memAck), .reqReady(reqReady), .rspValid(rspValid),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .strobe(strobe)
  );

  wbcDatapath #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqAddr(reqAddr),
    .lookHit(lookHit), .lookFree(lookFree), .lookDirty(lookDirty),
    .rspHit(rspHit), .memReqAddr(memReqAddr),
    .statReadHit(statReadHit), .statReadMiss(statReadMiss),
    .statWriteHit(statWriteHit), .statWriteMiss(statWriteMiss),
    .statWriteback(statWriteback)
  );
endmodule

// File: rtl/wbcChecker.sv
module wbcChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        rspValid,
  input logic        memReqValid,
  input logic        memReqWrite,
  input logic [31:0] memReqAddr,
  input logic        memAck,
  input logic [31:0] statReadHit,
  input logic [31:0] statReadMiss,
  input logic [31:0] statWriteHit,
  input logic [31:0] statWriteMiss
);
  logic [31:0] reqTotal;
  assign reqTotal = statReadHit + statReadMiss + statWriteHit + statWriteMiss;

  // R8: idle means nothing is pending below and no response is due
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !rspValid));

  // R8: a next-level command is held until acknowledged
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memAck) |=> (memReqValid && $stable(memReqWrite) && $stable(memReqAddr)));

  // R6: an acknowledged block write is followed directly by the block read
  a_r6_wb_then_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memAck) |=> (memReqValid && !memReqWrite));

  // R9: each response adds exactly one to the request counters
  a_r9_count_once: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (reqTotal == $past(reqTotal) + 32'd1));

  // R9: counters move only on a response
  a_r9_count_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |=> $stable(reqTotal));
endmodule

bind wbCacheCtrl wbcChecker chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
  .memAck(memAck), .statReadHit(statReadHit), .statReadMiss(statReadMiss),
  .statWriteHit(statWriteHit), .statWriteMiss(statWriteMiss)
);

// File: tb/wbCacheCtrl_tb.sv
module wbCacheCtrl_tb_top;
  localparam int CACHE_BYTES = 1024;
  localparam int WAYS        = 4;
  localparam int BLOCK_BYTES = 16;
  localparam int SETS  = CACHE_BYTES / (WAYS * BLOCK_BYTES);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, memAck = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqReady, rspValid, rspHit, memReqValid, memReqWrite;
  logic [31:0] memReqAddr;
  logic [31:0] statReadHit, statReadMiss, statWriteHit, statWriteMiss, statWriteback;

  always #2 clk = ~clk;  // 250 MHz

  wbCacheCtrl #(.CACHE_BYTES(CACHE_BYTES), .WAYS(WAYS), .BLOCK_BYTES(BLOCK_BYTES)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspHit(rspHit),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memAck(memAck), .statReadHit(statReadHit), .statReadMiss(statReadMiss),
    .statWriteHit(statWriteHit), .statWriteMiss(statWriteMiss), .statWriteback(statWriteback)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model: per set a recency list, most recent at the front
  int unsigned mTag   [SETS][$];
  bit          mDirty [SETS][$];
  bit          expWr   [$];
  logic [31:0] expAddr [$];
  int mReadHit = 0, mReadMiss = 0, mWriteHit = 0, mWriteMiss = 0, mWb = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(input int unsigned tag, input int unsigned set,
                                         input int unsigned off);
    return (32'(tag) << (OFF_W + IDX_W)) | (32'(set) << OFF_W) | 32'(off);
  endfunction

  function automatic bit modelAccess(input bit wr, input logic [31:0] addr);
    int unsigned set, tag;
    int found;
    bit d, hit;
    set = int'((addr >> OFF_W) & 32'(SETS - 1));
    tag = int'(addr >> (OFF_W + IDX_W));
    found = -1;
    foreach (mTag[set][i]) if (found < 0 && mTag[set][i] == tag) found = i;
    hit = (found >= 0);
    if (hit) begin
      d = mDirty[set][found] | wr;
      mTag[set].delete(found); mDirty[set].delete(found);
      if (wr) mWriteHit++; else mReadHit++;
    end else begin
      if (mTag[set].size() == WAYS) begin
        if (mDirty[set][WAYS-1]) begin
          expWr.push_back(1'b1);
          expAddr.push_back(mkAddr(mTag[set][WAYS-1], set, 0));
          mWb++;
        end
        void'(mTag[set].pop_back()); void'(mDirty[set].pop_back());
      end
      expWr.push_back(1'b0);
      expAddr.push_back(mkAddr(tag, set, 0));
      d = wr;
      if (wr) mWriteMiss++; else mReadMiss++;
    end
    mTag[set].push_front(tag); mDirty[set].push_front(d);
    return hit;
  endfunction

  task automatic doReq(input bit wr, input logic [31:0] addr, input string req);
    bit expHit, done;
    int guard;
    expHit = modelAccess(wr, addr);
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    done = 0; guard = 0;
    while (!done) begin
      guard++;
      if (guard > 60) begin
        check(1'b0, req, "request never completed", 32'(guard), 32'd0);
        done = 1;
      end else if (memReqValid) begin
        if (expWr.size() == 0) begin
          check(1'b0, req, "unexpected next-level command", memReqAddr, 32'hx);
        end else begin
          check(memReqWrite == expWr[0], expWr[0] ? "R6" : req, "command kind",
                32'(memReqWrite), 32'(expWr[0]));
          check(memReqAddr == expAddr[0], expWr[0] ? "R6" : req, "command address",
                memReqAddr, expAddr[0]);
          void'(expWr.pop_front()); void'(expAddr.pop_front());
        end
        memAck = 1'b1;
        @(negedge clk);
        memAck = 1'b0;
      end else if (rspValid) begin
        check(rspHit == expHit, req, "hit flag", 32'(rspHit), 32'(expHit));
        check(expWr.size() == 0, req, "missing next-level commands", 32'(expWr.size()), 32'd0);
        expWr.delete(); expAddr.delete();
        done = 1;
      end else begin
        check(reqReady == 1'b0, "R8", "ready while busy", 32'(reqReady), 32'd0);
        @(negedge clk);
      end
    end
  endtask

  task automatic checkStats(input string tag);
    @(negedge clk);
    check(statReadHit   == 32'(mReadHit),   "R9", {tag, " read hits"},    statReadHit,   32'(mReadHit));
    check(statReadMiss  == 32'(mReadMiss),  "R9", {tag, " read misses"},  statReadMiss,  32'(mReadMiss));
    check(statWriteHit  == 32'(mWriteHit),  "R9", {tag, " write hits"},   statWriteHit,  32'(mWriteHit));
    check(statWriteMiss == 32'(mWriteMiss), "R9", {tag, " write misses"}, statWriteMiss, 32'(mWriteMiss));
    check(statWriteback == 32'(mWb),        "R9", {tag, " writebacks"},   statWriteback, 32'(mWb));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(reqReady == 1'b1, "R10", "ready after reset", 32'(reqReady), 32'd1);
    check(memReqValid == 1'b0, "R10", "no command after reset", 32'(memReqValid), 32'd0);
    check(statReadHit + statReadMiss + statWriteHit + statWriteMiss + statWriteback == 0,
          "R10", "counters zero", statReadMiss, 32'd0);

    // R3: cold miss fills an invalid way, single block read
    doReq(1'b0, mkAddr(1, 3, 4), "R3");
    // R2 / R1: same block, other offsets, hits with no traffic
    doReq(1'b0, mkAddr(1, 3, 12), "R2");
    doReq(1'b0, mkAddr(1, 3, 0), "R1");
    // R4: write hit makes the block dirty without traffic
    doReq(1'b1, mkAddr(1, 3, 8), "R4");
    // R1: neighbouring set with the same tag is a separate block
    doReq(1'b0, mkAddr(1, 2, 0), "R1");
    // R3: fill the remaining ways of set 3
    doReq(1'b0, mkAddr(2, 3, 0), "R3");
    doReq(1'b0, mkAddr(3, 3, 0), "R3");
    doReq(1'b0, mkAddr(4, 3, 0), "R3");
    // R7: touch tag 1 again so tag 2 becomes least recent
    doReq(1'b0, mkAddr(1, 3, 0), "R7");
    // R5: clean LRU victims, fetch only
    doReq(1'b0, mkAddr(5, 3, 0), "R5");
    doReq(1'b0, mkAddr(6, 3, 0), "R5");
    doReq(1'b0, mkAddr(7, 3, 0), "R5");
    // R6: the dirty tag-1 block is now least recent; writeback precedes fetch
    doReq(1'b0, mkAddr(8, 3, 0), "R6");
    // R4: write miss allocates dirty; evicting it later writes it back
    doReq(1'b1, mkAddr(9, 3, 0), "R4");
    doReq(1'b0, mkAddr(10, 3, 0), "R5");
    doReq(1'b0, mkAddr(11, 3, 0), "R5");
    doReq(1'b0, mkAddr(12, 3, 0), "R5");
    doReq(1'b0, mkAddr(13, 3, 0), "R6");
    checkStats("directed");

    // R7: pseudo-random mix over a few tags and sets
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      doReq(lfsr[0], mkAddr(int'(lfsr[6:4]) % 6, int'(lfsr[9:8]), int'(lfsr[15:12])), "R7");
    end
    checkStats("random");
    finishRun();
  end
endmodule